// File: doc/BRIEF.md
# Serial/Parallel FIFO Write Front End

This block sits in front of the storage array of a 9-bit FIFO. It turns incoming data into single-cycle write requests. A mode input picks the source. In parallel mode a whole word is presented on a 9-bit bus together with a one-cycle write strobe. In serial mode, one bit arrives per rising edge of a free-running serial clock, and every nine bits become one write.

The serial clock and serial data are brought into the system clock domain by a short synchronizer. A marker bit then travels through a 9-bit shift register. When the marker arrives in the top position together with the incoming bit, the assembled word is issued as one entry and the register returns to idle.

A start-permission input supports cascading, so that one serial stream can be split across several devices. With the input held high, the device begins a new word on every serial edge at which it is idle. With the input held low, the device discards bits until the earlier stage marks the end of its slice. A completed word that arrives while the store reports full is dropped, and a one-cycle overflow pulse is raised instead.

Top module: `sp_in_port`

## Requirements
- R1: While rst_ni is low, wr_en_o, ovf_o and casc_o are all 0.
- R2: With par_mode_i = 1, a cycle with par_wr_i = 1 and fifo_full_i = 0 gives wr_en_o = 1 in the next cycle, with wr_data_o equal to par_d_i of the strobe cycle.
- R3: With par_mode_i = 0 and casc_i = 1, every nine rising edges of ser_clk_i produce one write. The bit sampled at the first of those edges lands in wr_data_o[8], and the bit sampled at the ninth lands in wr_data_o[0].
- R4: par_wr_i has no effect in serial mode, and ser_clk_i edges have no effect in parallel mode. In both cases no write and no overflow occurs.
- R5: In serial mode, an idle device starts a word only at a serial edge where casc_i = 1. That edge's bit becomes wr_data_o[8]. Bits at edges where the device is idle and casc_i = 0 are discarded.
- R6: casc_o goes to 1 after the serial edge that completes a word. It returns to 0 after the next serial edge, and it stays 0 in parallel mode.
- R7: A word that completes while fifo_full_i = 1 causes no write, and ovf_o pulses for one cycle instead. This applies in either mode.
- R8: Setting par_mode_i to 1 discards any partly assembled serial word. The next serial word after returning to serial mode is assembled from fresh bits.
- R9: Each accepted word gives exactly one cycle of wr_en_o, and wr_en_o and ovf_o are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| par_mode_i | input | 1 | 1 = parallel loading, 0 = serial loading |
| par_d_i | input | 9 | Parallel input word |
| par_wr_i | input | 1 | Parallel write strobe, one cycle per word |
| ser_clk_i | input | 1 | Serial clock, bits are taken on its rising edge |
| ser_d_i | input | 1 | Serial data bit |
| casc_i | input | 1 | Start permission: high for a standalone or leading device |
| casc_o | output | 1 | End-of-slice marker for the next device in a chain |
| fifo_full_i | input | 1 | Store is full |
| wr_en_o | output | 1 | Write request to the store |
| wr_data_o | output | 9 | Word to be written |
| ovf_o | output | 1 | One-cycle pulse for a word dropped on full |

## Verification
The properties assume a few things about the inputs:
- par_mode_i, par_wr_i, par_d_i and fifo_full_i are synchronous to clk_i.
- ser_clk_i and ser_d_i are slow against clk_i, with each serial level held for several system cycles.
- ser_d_i changes only while ser_clk_i is low, so the synchronized bit is stable at the detected edge.

The stimulus holds each serial level for four system cycles and changes data together with the falling level. Mode and strobe inputs are driven only at falling edges of clk_i. Mode switches are made only between strobes, with at least one serial idle period on either side.

// File: rtl/sp_in_pkg.sv
package sp_in_pkg;
  parameter int unsigned WORD_W = 9;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/sp_in_sync.sv
// Brings serial clock and data into clk_i domain; emits one step per rising edge.
module sp_in_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ser_clk_i,
  input  logic ser_d_i,
  output logic step_o,
  output logic bit_o
);
  localparam int unsigned TOP = STAGES - 1;

  logic [TOP:0] clk_q, dat_q;
  logic         clk_last;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          clk_q <= '0;
          dat_q <= '0;
        end else begin
          clk_q <= ser_clk_i;
          dat_q <= ser_d_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          clk_q <= '0;
          dat_q <= '0;
        end else begin
          clk_q <= {clk_q[TOP-1:0], ser_clk_i};
          dat_q <= {dat_q[TOP-1:0], ser_d_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clk_last <= 1'b0;
    else         clk_last <= clk_q[TOP];
  end

  assign step_o = clk_q[TOP] & ~clk_last;
  assign bit_o  = dat_q[TOP];
endmodule

// File: rtl/sp_in_shifter.sv
// Marker shift register: all-zero = idle, a single leading 1 tracks bit count.
module sp_in_shifter
  import sp_in_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  hold_i,
  input  logic  step_i,
  input  logic  bit_i,
  input  logic  casc_i,
  output logic  done_o,
  output word_t word_o,
  output logic  busy_o,
  output logic  casc_o
);
  localparam int unsigned MSB = WORD_W - 1;

  word_t sr_q;
  logic  idle;

  assign idle   = (sr_q == '0);
  assign busy_o = ~idle;
  assign done_o = step_i & ~hold_i & sr_q[MSB];
  assign word_o = {sr_q[MSB-1:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      casc_o <= 1'b0;
    end else if (hold_i) begin
      sr_q   <= '0;
      casc_o <= 1'b0;
    end else if (step_i) begin
      casc_o <= sr_q[MSB];
      if (idle) begin
        sr_q <= casc_i ? word_t'({1'b1, bit_i}) : '0;
      end else if (sr_q[MSB]) begin
        sr_q <= '0;
      end else begin
        sr_q <= {sr_q[MSB-1:0], bit_i};
      end
    end
  end
endmodule

// File: rtl/sp_in_wr_stage.sv
// Selects the word source, applies the full check, registers the write.
module sp_in_wr_stage
  import sp_in_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  par_mode_i,
  input  logic  par_wr_i,
  input  word_t par_d_i,
  input  logic  ser_done_i,
  input  word_t ser_word_i,
  input  logic  full_i,
  output logic  wr_en_o,
  output word_t wr_data_o,
  output logic  ovf_o
);
  logic  cand;
  word_t cand_data;

  always_comb begin
    cand      = par_mode_i ? par_wr_i : ser_done_i;
    cand_data = par_mode_i ? par_d_i  : ser_word_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o   <= 1'b0;
      ovf_o     <= 1'b0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= cand & ~full_i;
      ovf_o   <= cand & full_i;
      if (cand & ~full_i) wr_data_o <= cand_data;
    end
  end
endmodule

// File: rtl/sp_in_port.sv
module sp_in_port
  import sp_in_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              par_mode_i,
  input  logic [WORD_W-1:0] par_d_i,
  input  logic              par_wr_i,
  input  logic              ser_clk_i,
  input  logic              ser_d_i,
  input  logic              casc_i,
  output logic              casc_o,
  input  logic              fifo_full_i,
  output logic              wr_en_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic              ovf_o
);
  logic  ser_step, ser_bit, ser_done, ser_busy;
  word_t ser_word;

  sp_in_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ser_clk_i(ser_clk_i),
    .ser_d_i  (ser_d_i),
    .step_o   (ser_step),
    .bit_o    (ser_bit)
  );

  sp_in_shifter i_shifter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hold_i(par_mode_i),
    .step_i(ser_step),
    .bit_i (ser_bit),
    .casc_i(casc_i),
    .done_o(ser_done),
    .word_o(ser_word),
    .busy_o(ser_busy),
    .casc_o(casc_o)
  );

  sp_in_wr_stage i_wr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .par_mode_i(par_mode_i),
    .par_wr_i  (par_wr_i),
    .par_d_i   (par_d_i),
    .ser_done_i(ser_done),
    .ser_word_i(ser_word),
    .full_i    (fifo_full_i),
    .wr_en_o   (wr_en_o),
    .wr_data_o (wr_data_o),
    .ovf_o     (ovf_o)
  );
endmodule

// File: rtl/sp_in_port_chk.sv
module sp_in_port_chk
  import sp_in_pkg::*;
(
  input logic  clk_i,
  input logic  rst_ni,
  input logic  par_mode_i,
  input word_t par_d_i,
  input logic  par_wr_i,
  input logic  fifo_full_i,
  input logic  casc_o,
  input logic  wr_en_o,
  input word_t wr_data_o,
  input logic  ovf_o,
  input logic  ser_done,
  input word_t ser_word,
  input logic  ser_busy
);
  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> !wr_en_o && !ovf_o && !casc_o);

  a_r2_par_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_mode_i && par_wr_i && !fifo_full_i |=> wr_en_o && wr_data_o == $past(par_d_i));

  a_r3_ser_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_done && !fifo_full_i |=> wr_en_o && wr_data_o == $past(ser_word));

  a_r4_no_stray_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o || ovf_o) |-> $past(par_mode_i ? par_wr_i : ser_done));

  a_r6_casc_mark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_done |=> casc_o);

  a_r7_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_mode_i ? par_wr_i : ser_done) && fifo_full_i |=> ovf_o && !wr_en_o);

  a_r8_park: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_mode_i |=> !ser_busy && !casc_o);

  a_r9_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_o && ovf_o));
endmodule

bind sp_in_port sp_in_port_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .par_mode_i (par_mode_i),
  .par_d_i    (par_d_i),
  .par_wr_i   (par_wr_i),
  .fifo_full_i(fifo_full_i),
  .casc_o     (casc_o),
  .wr_en_o    (wr_en_o),
  .wr_data_o  (wr_data_o),
  .ovf_o      (ovf_o),
  .ser_done   (ser_done),
  .ser_word   (ser_word),
  .ser_busy   (ser_busy)
);

// File: tb/test_sp_in_port.sv
`timescale 1ns/1ps
module test_sp_in_port;
  import sp_in_pkg::*;

  logic  clk = 1'b0;
  logic  rst_n = 1'b0;
  logic  par_mode = 1'b0, par_wr = 1'b0, ser_clk = 1'b0, ser_d = 1'b0;
  logic  casc_in = 1'b1, full = 1'b0;
  word_t par_d = '0;
  logic  casc_out, wr_en, ovf;
  word_t wr_data;

  int    n_checks = 0, n_fail = 0, ovf_seen = 0, ovf_exp = 0;
  word_t exp_q[$];
  bit    done = 1'b0;

  always #4 clk = ~clk;

  sp_in_port i_sp_in_port (
    .clk_i(clk), .rst_ni(rst_n), .par_mode_i(par_mode), .par_d_i(par_d),
    .par_wr_i(par_wr), .ser_clk_i(ser_clk), .ser_d_i(ser_d), .casc_i(casc_in),
    .casc_o(casc_out), .fifo_full_i(full), .wr_en_o(wr_en), .wr_data_o(wr_data),
    .ovf_o(ovf)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected words as writes appear (R2, R3, R4, R9)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (wr_en) begin
        if (exp_q.size() == 0) check(1'b0, "R4 unexpected write", wr_data, 0);
        else begin
          word_t e;
          e = exp_q.pop_front();
          check(wr_data == e, "R3/R2 write data", wr_data, e);
        end
      end
      if (ovf) ovf_seen++;
      if (wr_en && ovf) check(1'b0, "R9 write with overflow", 1, 0);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic par_put(input word_t d, input bit exp_drop);
    @(negedge clk);
    par_d = d; par_wr = 1'b1;
    if (exp_drop) ovf_exp++; else exp_q.push_back(d);
    @(negedge clk);
    par_wr = 1'b0;
  endtask

  task automatic ser_bit(input bit b);
    @(negedge clk);
    ser_clk = 1'b0; ser_d = b;
    cyc(4);
    ser_clk = 1'b1;
    cyc(4);
  endtask

  task automatic ser_word(input word_t w, input bit exp_drop);
    if (exp_drop) ovf_exp++; else exp_q.push_back(w);
    for (int i = WORD_W - 1; i >= 0; i--) ser_bit(w[i]);
  endtask

  task automatic drain(input string req);
    cyc(4);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
    check(ovf_seen == ovf_exp, req, ovf_seen, ovf_exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(3);
    // R1 reset state
    check(!wr_en && !ovf && !casc_out, "R1 reset outputs", {wr_en, ovf, casc_out}, 0);
    rst_n = 1'b1;
    cyc(3);

    // R2 parallel words, random and back to back
    par_mode = 1'b1;
    cyc(2);
    for (int i = 0; i < 20; i++) par_put(word_t'($urandom), 1'b0);
    @(negedge clk); par_d = 9'h1a5; par_wr = 1'b1; exp_q.push_back(9'h1a5);
    @(negedge clk); par_d = 9'h05a; exp_q.push_back(9'h05a);
    @(negedge clk); par_wr = 1'b0;
    drain("R2 parallel writes");

    // R7 full in parallel mode
    full = 1'b1;
    par_put(9'h0ff, 1'b1);
    cyc(2);
    full = 1'b0;
    drain("R7 parallel drop on full");

    // R4 serial edges ignored in parallel mode
    for (int i = 0; i < 12; i++) ser_bit(1'b1);
    drain("R4 serial ignored in parallel");
    check(!casc_out, "R6 casc low in parallel", casc_out, 0);

    // R3 serial words, casc high
    par_mode = 1'b0;
    cyc(4);
    ser_word(9'h100, 1'b0);
    ser_word(9'h001, 1'b0);
    for (int i = 0; i < 10; i++) ser_word(word_t'($urandom), 1'b0);
    drain("R3 serial writes");

    // R6 casc_o marks completion, cleared by the next edge
    ser_word(9'h0c3, 1'b0);
    check(casc_out == 1'b1, "R6 casc after completion", casc_out, 1);
    casc_in = 1'b0;
    ser_bit(1'b1);
    check(casc_out == 1'b0, "R6 casc cleared", casc_out, 0);

    // R5 idle with casc low discards bits; start on casc high
    for (int i = 0; i < 5; i++) ser_bit(1'b1);
    drain("R5 discarded while waiting");
    @(negedge clk); casc_in = 1'b1;
    exp_q.push_back(9'h0b6);
    ser_bit(1'b0);
    casc_in = 1'b0;
    for (int i = WORD_W - 2; i >= 0; i--) ser_bit(9'h0b6 >> i);
    drain("R5 word after start");
    casc_in = 1'b1;

    // R4 par_wr ignored in serial mode
    @(negedge clk); par_d = 9'h1ee; par_wr = 1'b1;
    cyc(3); par_wr = 1'b0;
    drain("R4 parallel strobe ignored in serial");

    // R7 full in serial mode
    full = 1'b1;
    ser_word(9'h155, 1'b1);
    full = 1'b0;
    drain("R7 serial drop on full");

    // R8 partial word discarded by mode switch
    for (int i = 0; i < 4; i++) ser_bit(1'b1);
    @(negedge clk); par_mode = 1'b1;
    cyc(2);
    par_put(9'h077, 1'b0);
    cyc(2);
    par_mode = 1'b0;
    cyc(4);
    ser_word(9'h0aa, 1'b0);
    drain("R8 fresh word after mode switch");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule